// File: doc/BRIEF.md
# Accumulator ALU with status word update

This block is the arithmetic unit of an accumulator-based 8-bit core. Each cycle it takes an operation code, the accumulator value, a second operand (which also serves as the B register for multiply and divide), a single boolean bit operand and the current program status word. One cycle later it presents the new accumulator, the new B value and the updated status word. All outputs are registered.

The unit performs binary add with and without carry-in, subtract with borrow, decimal adjust of a packed-BCD sum, an unsigned multiply that splits its 16-bit product between the accumulator and B, an unsigned divide that returns quotient and remainder, and AND/OR of the carry flag with a bit operand. The status word carries carry, auxiliary (nibble) carry, overflow and even parity. It also carries a user flag, two bank-select bits and one spare bit, which the unit passes through untouched. Operand fetch and logical byte operations live elsewhere in the core.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `acc_out`, `b_out` and `psw_out` become zero.
- R2: Op 1 (add) and op 2 (add with carry-in taken from psw_in bit 7) give `acc_out` = (acc + opnd + cin) mod 256. Bit 7 is set to the carry out of bit 7. Bit 6 is set to the carry out of bit 3. Bit 2 is set when the signed sum lies outside -128..+127.
- R3: Op 3 (subtract with borrow) gives `acc_out` = (acc - opnd - psw_in[7]) mod 256. Bit 7 is the borrow out of bit 7. Bit 6 is the borrow out of bit 3. Bit 2 is set when the signed difference lies outside -128..+127.
- R4: Op 4 (decimal adjust) first adds 06h to the accumulator if its low nibble exceeds 9 or psw_in[6] is set. If that step, psw_in[7] or a high nibble above 9 calls for it, 60h is then added to the intermediate value and bit 7 is set. Otherwise bit 7 is cleared. Bits 6 and 2 are kept.
- R5: Op 5 (multiply) returns the low byte of acc*opnd on `acc_out` and the high byte on `b_out`. It clears bit 7 and sets bit 2 exactly when the product exceeds FFh.
- R6: Op 6 (divide) with a nonzero divisor returns floor(acc/opnd) on `acc_out` and acc mod opnd on `b_out`. It clears bits 7 and 2.
- R7: Op 6 with a zero divisor sets bit 2 and clears bit 7. It returns `acc_out` = acc and `b_out` = opnd unchanged.
- R8: Op 7 sets bit 7 to psw_in[7] AND `bit_in`. Op 8 sets bit 7 to psw_in[7] OR `bit_in`. Both leave the accumulator and B unchanged.
- R9: `psw_out` bit 0 always equals the XOR of all bits of `acc_out`, under every operation including reset.
- R10: Bits 5, 4, 3 and 1 of `psw_out` always copy `psw_in`. Op 0 and codes 9 to 15 pass the accumulator, B and bits 7, 6, 2 through unchanged. Each result appears on the outputs after exactly one rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code (0 pass, 1 add, 2 add with carry, 3 subtract with borrow, 4 decimal adjust, 5 multiply, 6 divide, 7 carry AND, 8 carry OR) |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand / B register |
| bit_in | input | 1 | Boolean bit operand for carry AND/OR |
| psw_in | input | 8 | Current status word (7 carry, 6 aux carry, 5 user flag, 4:3 bank select, 2 overflow, 1 spare, 0 parity) |
| acc_out | output | 8 | Registered accumulator result |
| b_out | output | 8 | Registered B result |
| psw_out | output | 8 | Registered status word, same bit layout as psw_in |

## Verification
The add-with-carry and subtract-with-borrow sweeps cover every operand pair. These sweeps catch a nibble carry taken from the wrong bit, an overflow formed from unsigned carry, and a borrow with the wrong polarity, any of which would flip bit 6, 2 or 7 on a subset of vectors. Decimal adjust runs over all 256 accumulator values with each combination of incoming carry and auxiliary carry. This exposes a design that skips the 60h step when the 06h step wraps past FFh, or that fails to clear carry when no high correction occurs. The multiply and divide sweeps include products just above FFh and divisors of zero and one. They catch swapped product bytes, overflow misreported at the FFh boundary, and a zero-divide that corrupts the accumulator. Pseudo-random status inputs confirm that the user and bank bits never move and that parity follows the new accumulator rather than the old one.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_PASS = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADDC = 4'd2,
    OP_SUBB = 4'd3,
    OP_DADJ = 4'd4,
    OP_MUL  = 4'd5,
    OP_DIV  = 4'd6,
    OP_CAND = 4'd7,
    OP_COR  = 4'd8
  } alu_op_e;

  // status word bit positions
  localparam int SW_CY  = 7;
  localparam int SW_AC  = 6;
  localparam int SW_OV  = 2;
  localparam int SW_PAR = 0;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] r,
  output logic         cy,
  output logic         ac,
  output logic         ov
);
  localparam int NW = W / 2;

  logic [NW:0] lo;
  logic [W:0]  full;

  always_comb begin
    if (sub) begin
      lo   = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
      full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
    end else begin
      lo   = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
      full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end
    r  = full[W-1:0];
    cy = full[W];
    ac = lo[NW];
    if (sub) ov = (a[W-1] ^ b[W-1]) & (r[W-1] ^ a[W-1]);
    else     ov = ~(a[W-1] ^ b[W-1]) & (r[W-1] ^ a[W-1]);
  end

endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cy_in,
  input  logic         ac_in,
  output logic [W-1:0] r,
  output logic         cy_out
);
  localparam int NW = W / 2;
  localparam logic [W:0]  ADJ_LO = (W+1)'(6);
  localparam logic [W:0]  ADJ_HI = (W+1)'(6) << NW;
  localparam logic [NW-1:0] DIG_MAX = NW'(9);

  logic [W:0]   step1;
  logic [W-1:0] mid;
  logic         hi_fix;
  logic [W:0]   step2;

  always_comb begin
    step1  = (a[NW-1:0] > DIG_MAX || ac_in) ? ({1'b0, a} + ADJ_LO) : {1'b0, a};
    mid    = step1[W-1:0];
    hi_fix = cy_in | step1[W] | (mid[W-1:NW] > DIG_MAX);
    step2  = hi_fix ? ({1'b0, mid} + ADJ_HI) : {1'b0, mid};
    r      = step2[W-1:0];
    cy_out = hi_fix;
  end

endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod,
  output logic [W-1:0]   quo,
  output logic [W-1:0]   rem,
  output logic           dz
);
  logic [W:0] part;

  assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign dz   = (b == '0);

  // restoring division, one quotient bit per step, fully unrolled
  always_comb begin
    part = '0;
    quo  = '0;
    for (int i = W - 1; i >= 0; i--) begin
      part = {part[W-1:0], a[i]};
      if (part >= {1'b0, b}) begin
        part   = part - {1'b0, b};
        quo[i] = 1'b1;
      end
    end
    rem = part[W-1:0];
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   acc_in,
  input  logic [W-1:0]   opnd_in,
  input  logic           bit_in,
  input  logic [W-1:0]   psw_in,
  output logic [W-1:0]   acc_out,
  output logic [W-1:0]   b_out,
  output logic [W-1:0]   psw_out
);
  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  logic [W-1:0]   as_r;
  logic           as_cy, as_ac, as_ov;
  logic [W-1:0]   da_r;
  logic           da_cy;
  logic [2*W-1:0] md_prod;
  logic [W-1:0]   md_quo, md_rem;
  logic           md_dz;

  acc_alu_addsub #(.W(W)) u_addsub (
    .a   (acc_in),
    .b   (opnd_in),
    .cin ((op_e != OP_ADD) & psw_in[SW_CY]),
    .sub (op_e == OP_SUBB),
    .r   (as_r),
    .cy  (as_cy),
    .ac  (as_ac),
    .ov  (as_ov)
  );

  acc_alu_decadj #(.W(W)) u_decadj (
    .a      (acc_in),
    .cy_in  (psw_in[SW_CY]),
    .ac_in  (psw_in[SW_AC]),
    .r      (da_r),
    .cy_out (da_cy)
  );

  acc_alu_muldiv #(.W(W)) u_muldiv (
    .a    (acc_in),
    .b    (opnd_in),
    .prod (md_prod),
    .quo  (md_quo),
    .rem  (md_rem),
    .dz   (md_dz)
  );

  logic [W-1:0] nx_acc, nx_b, nx_psw;
  logic         nx_cy, nx_ac, nx_ov;

  always_comb begin
    nx_acc = acc_in;
    nx_b   = opnd_in;
    nx_cy  = psw_in[SW_CY];
    nx_ac  = psw_in[SW_AC];
    nx_ov  = psw_in[SW_OV];
    unique case (op_e)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        nx_acc = as_r;
        nx_cy  = as_cy;
        nx_ac  = as_ac;
        nx_ov  = as_ov;
      end
      OP_DADJ: begin
        nx_acc = da_r;
        nx_cy  = da_cy;
      end
      OP_MUL: begin
        nx_acc = md_prod[W-1:0];
        nx_b   = md_prod[2*W-1:W];
        nx_cy  = 1'b0;
        nx_ov  = |md_prod[2*W-1:W];
      end
      OP_DIV: begin
        nx_cy = 1'b0;
        nx_ov = md_dz;
        if (!md_dz) begin
          nx_acc = md_quo;
          nx_b   = md_rem;
        end
      end
      OP_CAND: nx_cy = psw_in[SW_CY] & bit_in;
      OP_COR:  nx_cy = psw_in[SW_CY] | bit_in;
      default: ;
    endcase
    nx_psw         = psw_in;
    nx_psw[SW_CY]  = nx_cy;
    nx_psw[SW_AC]  = nx_ac;
    nx_psw[SW_OV]  = nx_ov;
    nx_psw[SW_PAR] = ^nx_acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out <= '0;
      b_out   <= '0;
      psw_out <= '0;
    end else begin
      acc_out <= nx_acc;
      b_out   <= nx_b;
      psw_out <= nx_psw;
    end
  end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [OPW-1:0] op,
  input logic [W-1:0]   acc_in,
  input logic [W-1:0]   opnd_in,
  input logic [W-1:0]   psw_in,
  input logic [W-1:0]   acc_out,
  input logic [W-1:0]   b_out,
  input logic [W-1:0]   psw_out
);
  localparam int DW = 2 * W;

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (acc_out == '0 && b_out == '0 && psw_out == '0));

  a_r9_parity: assert property (@(posedge clk) disable iff (rst)
    psw_out[SW_PAR] == ^acc_out);

  a_r5_mul_split: assert property (@(posedge clk) disable iff (rst)
    ($past(op) == OP_MUL && !$past(rst))
    |-> ({b_out, acc_out} == DW'($past(acc_in)) * DW'($past(opnd_in))));

  a_r6_div_identity: assert property (@(posedge clk) disable iff (rst)
    ($past(op) == OP_DIV && $past(opnd_in) != '0 && !$past(rst))
    |-> (DW'(acc_out) * DW'($past(opnd_in)) + DW'(b_out) == DW'($past(acc_in))
         && b_out < $past(opnd_in)));

  a_r7_divzero_flag: assert property (@(posedge clk) disable iff (rst)
    ($past(op) == OP_DIV && $past(opnd_in) == '0 && !$past(rst))
    |-> (psw_out[SW_OV] && !psw_out[SW_CY] && acc_out == $past(acc_in)));

  a_r10_bank_kept: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (psw_out[5:3] == $past(psw_in[5:3]) && psw_out[1] == $past(psw_in[1])));

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_acc_alu_chk (
  .clk     (clk),
  .rst     (rst),
  .op      (op),
  .acc_in  (acc_in),
  .opnd_in (opnd_in),
  .psw_in  (psw_in),
  .acc_out (acc_out),
  .b_out   (b_out),
  .psw_out (psw_out)
);

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op = '0;
  logic [7:0] acc_in = '0, opnd_in = '0, psw_in = '0;
  logic       bit_in = 1'b0;
  logic [7:0] acc_out, b_out, psw_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  acc_alu i_acc_alu (
    .clk(clk), .rst(rst), .op(op), .acc_in(acc_in), .opnd_in(opnd_in),
    .bit_in(bit_in), .psw_in(psw_in), .acc_out(acc_out), .b_out(b_out),
    .psw_out(psw_out)
  );

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int par8(input int v);
    int p = 0;
    for (int i = 0; i < 8; i++) p ^= (v >> i) & 1;
    return p;
  endfunction

  // expected outputs from the requirement text
  function automatic void expect_of(input int o, input int a, input int b,
                                    input int bt, input int ps,
                                    output int ea, output int eb, output int ep);
    int cy, ac, ov, c, s, sa, v, c1;
    cy = (ps >> 7) & 1; ac = (ps >> 6) & 1; ov = (ps >> 2) & 1;
    ea = a; eb = b;
    case (o)
      1, 2: begin
        c  = (o == 2) ? cy : 0;
        s  = a + b + c;
        ac = ((a & 15) + (b & 15) + c) > 15;
        cy = s > 255;
        sa = sx(a) + sx(b) + c;
        ov = (sa > 127 || sa < -128);
        ea = s & 255;
      end
      3: begin
        c  = cy;
        s  = a - b - c;
        ac = ((a & 15) - (b & 15) - c) < 0;
        cy = s < 0;
        sa = sx(a) - sx(b) - c;
        ov = (sa > 127 || sa < -128);
        ea = s & 255;
      end
      4: begin
        v = a;
        if ((v & 15) > 9 || ac) v += 6;
        c1 = v > 255;
        v &= 255;
        if (((v >> 4) > 9) || cy || c1) begin v += 96; cy = 1; end
        else cy = 0;
        ea = v & 255;
      end
      5: begin
        v = a * b;
        ea = v & 255; eb = v >> 8; cy = 0; ov = v > 255;
      end
      6: begin
        cy = 0;
        if (b == 0) ov = 1;
        else begin ea = a / b; eb = a % b; ov = 0; end
      end
      7: cy = cy & bt;
      8: cy = cy | bt;
      default: ;
    endcase
    ep = (ps & 8'h3A) | (cy << 7) | (ac << 6) | (ov << 2) | par8(ea);
  endfunction

  task automatic apply(input int o, input int a, input int b, input int bt,
                       input int ps, input string tag);
    int ea, eb, ep;
    op = 4'(o); acc_in = 8'(a); opnd_in = 8'(b); bit_in = 1'(bt); psw_in = 8'(ps);
    expect_of(o, a, b, bt, ps, ea, eb, ep);
    @(posedge clk); #1;
    n_vec++;
    if (acc_out !== 8'(ea) || b_out !== 8'(eb) || psw_out !== 8'(ep)) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%02h b=%02h psw_in=%02h: got acc=%02h b=%02h psw=%02h, expected acc=%02h b=%02h psw=%02h",
               tag, o, a, b, ps, acc_out, b_out, psw_out, ea, eb, ep);
    end
  endtask

  initial begin
    // R1: reset with busy inputs
    op = 4'd5; acc_in = 8'hFF; opnd_in = 8'hFF; psw_in = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if (acc_out !== 8'h00 || b_out !== 8'h00 || psw_out !== 8'h00) begin
      n_bad++;
      $display("FAIL R1 reset: got acc=%02h b=%02h psw=%02h, expected 00 00 00",
               acc_out, b_out, psw_out);
    end
    rst = 1'b0;

    // R2 corner: FFh + 1 wraps with carry and nibble carry
    apply(1, 8'hFF, 8'h01, 0, 8'h00, "R2");
    apply(1, 8'h7F, 8'h01, 0, 8'h00, "R2");
    apply(3, 8'h80, 8'h01, 0, 8'h00, "R3");
    apply(3, 8'h00, 8'h00, 0, 8'h80, "R3");

    // R2: add with carry, every pair
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply(2, a, b, 0, (a * 37 + b * 11) & 255, "R2");
    // R2: plain add, carry-in ignored
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 7)
        apply(1, a, b, 0, (a * 13 + b * 5) | 8'h80, "R2");
    // R3: subtract with borrow, every pair
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply(3, a, b, 0, (a * 29 + b * 23) & 255, "R3");
    // R4: decimal adjust for every accumulator and flag pair
    for (int a = 0; a < 256; a++)
      for (int f = 0; f < 4; f++)
        apply(4, a, a ^ 8'h5A, 0, (f << 6) | (a & 8'h3F), "R4");
    // R5: multiply, including FFh boundary
    apply(5, 8'h0F, 8'h11, 0, 8'hC4, "R5");
    apply(5, 8'h10, 8'h10, 0, 8'h80, "R5");
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 5)
        apply(5, a, b, 0, (a * 7 + b) & 255, "R5");
    // R6 / R7: divide, with zero and one divisors in the sweep
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 5) begin
        apply(6, a, b, 0, (a * 3 + b * 17) & 255, (b == 0) ? "R7" : "R6");
        if (b == 0) apply(6, a, 1, 0, 8'hC4, "R6");
      end
    // R8: carry AND / OR truth tables
    for (int c = 0; c < 2; c++)
      for (int bt = 0; bt < 2; bt++) begin
        apply(7, 8'h3C, 8'hA5, bt, (c << 7) | 8'h2D, "R8");
        apply(8, 8'h3C, 8'hA5, bt, (c << 7) | 8'h12, "R8");
      end
    // R9 / R10: pass and unassigned codes keep state, parity follows acc
    for (int o = 0; o < 16; o++)
      if (o == 0 || o > 8)
        for (int k = 0; k < 8; k++)
          apply(o, (k * 53 + o) & 255, (k * 91) & 255, k & 1, (k * 45 + o * 7) & 255,
                (k & 1) ? "R9" : "R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no completion, expected end of run");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule